// File: doc/BRIEF.md
# Dual Alarm Match Unit

This block keeps two independent alarm register sets and, once per seconds tick, compares each against the live calendar held by a neighbouring timekeeper. The calendar arrives as BCD fields for seconds, minutes, hours, weekday, date and month. Each alarm has its own 3-bit match-mode field, which selects how much of the calendar must agree. Each alarm also has a sticky interrupt flag that hardware sets and only a host clear pulse removes.

Both alarms share one multi-function output pin. While at least one alarm is enabled, the pin shows a single shared polarity level whenever an enabled alarm's flag is up, and the inverse of that level otherwise. While no alarm is enabled, the pin follows a general-purpose output bit. A host programs the alarm fields and a small control register through a simple write port. It clears flags with per-alarm pulses.

Top module: `dual_alarm_unit`

## Requirements
- R1: After synchronous reset, both flags read 0, both alarms are disabled, the general-purpose bit and the polarity are 0, and the pin reads 0.
- R2: Matching is evaluated only in the cycle after `sec_tick` is sampled high. A flag becomes visible two clock edges after that tick edge. With no tick, a standing match never sets a flag.
- R3: Mode 000 fires when the alarm seconds equal `now_sec`. Mode 001 fires when the alarm minutes equal `now_min`.
- R4: Mode 010 compares hour bits [5:0]. In 12-hour format (`now_hour[6]`=1), bit 5 is the PM bit, so AM and PM hours differ.
- R5: Bit 6 of a written alarm hour is ignored. The format bit always mirrors `now_hour[6]`.
- R6: Mode 011 fires only at midnight of the matching weekday: seconds 00, minutes 00, and hour 0x00 in 24-hour format or 0x52 (12 AM) in 12-hour format.
- R7: Mode 100 fires when the alarm date equals `now_date`.
- R8: Mode 111 fires only when seconds, minutes, hour bits [5:0], weekday, date and month all agree.
- R9: Codes 101 and 110 never set a flag.
- R10: A flag stays set until its `flag_clr` bit is pulsed. When a match and a clear hit the same edge, the flag ends up set.
- R11: Control register (address 0x10) layout: bit 0 is the general-purpose bit, bit 1 enables alarm 0, bit 2 enables alarm 1, bit 3 is the polarity. A disabled alarm never sets its flag.
- R12: With any alarm enabled, the pin is the polarity when an enabled flag is set and its inverse otherwise. The pin lags the flags and the control register by one edge.
- R13: With no alarm enabled, the pin equals the general-purpose bit. Alarm field addresses are {0, alarm index, field}, with these field codes: 0 seconds, 1 minutes, 2 hour, 3 config (weekday in [2:0], mode in [6:4]), 4 date, 5 month.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe, high when the calendar has just advanced |
| now_sec | input | 7 | Current BCD seconds |
| now_min | input | 7 | Current BCD minutes |
| now_hour | input | 7 | Current hour; bit 6 selects 12-hour format, bit 5 is PM or tens |
| now_wday | input | 3 | Current weekday 1..7 |
| now_date | input | 6 | Current BCD date |
| now_month | input | 5 | Current BCD month |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Write address |
| reg_wdata | input | 7 | Write data |
| flag_clr | input | 2 | Per-alarm flag clear pulses |
| alarm_flag | output | 2 | Alarm interrupt flags |
| mfp_out | output | 1 | Shared multi-function output level |

## Verification
If `sec_tick` is sampled at edge E0, the match is evaluated at E1 and the flag is readable after E1. The pin follows at E2. A register write or a clear at edge E0 changes the flag at E0 and the pin at E1. The bench drives stimuli on falling edges and samples on falling edges, and every task waits exactly the number of edges above before it checks. The case where a clear and a match meet on one edge is driven so that the clear pulse coincides with E1.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int REG_DW = 7;

  typedef enum logic [2:0] {
    MM_SEC  = 3'b000,
    MM_MIN  = 3'b001,
    MM_HOUR = 3'b010,
    MM_WDAY = 3'b011,
    MM_DATE = 3'b100,
    MM_RSV5 = 3'b101,
    MM_RSV6 = 3'b110,
    MM_FULL = 3'b111
  } match_mode_e;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hour;
    logic [2:0] wday;
    logic [5:0] date;
    logic [4:0] month;
  } cal_t;

  localparam logic [2:0] FLD_SEC   = 3'd0;
  localparam logic [2:0] FLD_MIN   = 3'd1;
  localparam logic [2:0] FLD_HOUR  = 3'd2;
  localparam logic [2:0] FLD_CFG   = 3'd3;
  localparam logic [2:0] FLD_DATE  = 3'd4;
  localparam logic [2:0] FLD_MONTH = 3'd5;
endpackage

// File: rtl/alm_slot.sv
module alm_slot
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_fld,
  input  logic [REG_DW-1:0] wr_data,
  input  cal_t              now,
  input  logic              eval_i,
  input  logic              en_i,
  input  logic              clr_i,
  output logic              flag_o
);
  logic [6:0]  a_sec, a_min;
  logic [5:0]  a_hour;
  logic [2:0]  a_wday;
  logic [5:0]  a_date;
  logic [4:0]  a_month;
  match_mode_e a_mode;
  logic        flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sec   <= '0;
      a_min   <= '0;
      a_hour  <= '0;
      a_wday  <= 3'd1;
      a_date  <= 6'h01;
      a_month <= 5'h01;
      a_mode  <= MM_SEC;
    end else if (wr_en) begin
      case (wr_fld)
        FLD_SEC:   a_sec   <= wr_data[6:0];
        FLD_MIN:   a_min   <= wr_data[6:0];
        FLD_HOUR:  a_hour  <= wr_data[5:0];
        FLD_CFG: begin
          a_wday <= wr_data[2:0];
          a_mode <= match_mode_e'(wr_data[6:4]);
        end
        FLD_DATE:  a_date  <= wr_data[5:0];
        FLD_MONTH: a_month <= wr_data[4:0];
        default: ;
      endcase
    end
  end

  logic eq_sec, eq_min, eq_hour, eq_wday, eq_date, eq_month, midnight, hit;

  always_comb begin
    eq_sec   = (now.sec == a_sec);
    eq_min   = (now.min == a_min);
    eq_hour  = (now.hour[5:0] == a_hour);
    eq_wday  = (now.wday == a_wday);
    eq_date  = (now.date == a_date);
    eq_month = (now.month == a_month);
    midnight = now.hour[6] ? (now.hour[5:0] == 6'h12) : (now.hour[5:0] == 6'h00);
    case (a_mode)
      MM_SEC:  hit = eq_sec;
      MM_MIN:  hit = eq_min;
      MM_HOUR: hit = eq_hour;
      MM_WDAY: hit = eq_wday && midnight && (now.min == 7'h00) && (now.sec == 7'h00);
      MM_DATE: hit = eq_date;
      MM_FULL: hit = eq_sec && eq_min && eq_hour && eq_wday && eq_date && eq_month;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                        flag_q <= 1'b0;
    else if (eval_i && en_i && hit) flag_q <= 1'b1;
    else if (clr_i)                 flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_FLAG_NEEDS_EVAL: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(eval_i)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q); // R10
  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && (a_mode == MM_RSV5 || a_mode == MM_RSV6)) |=> !flag_q); // R9
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !en_i) |=> !flag_q); // R11
endmodule

// File: rtl/alm_pin.sv
module alm_pin #(
  parameter int NUM_ALARM = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_ALARM-1:0] en,
  input  logic [NUM_ALARM-1:0] flags,
  input  logic                 pol,
  input  logic                 gp,
  output logic                 pin
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst)       pin_q <= 1'b0;
    else if (|en)  pin_q <= (|(flags & en)) ? pol : ~pol;
    else           pin_q <= gp;
  end

  assign pin = pin_q;

  AST_PIN_STEADY: assert property (@(posedge clk) disable iff (rst)
    ($stable(en) && $stable(flags) && $stable(pol) && $stable(gp)) |=> $stable(pin_q)); // R12
endmodule

// File: rtl/dual_alarm_unit.sv
module dual_alarm_unit
  import alm_pkg::*;
#(
  parameter int NUM_ALARM = 2,
  localparam int IDX_W  = (NUM_ALARM > 1) ? $clog2(NUM_ALARM) : 1,
  localparam int ADDR_W = IDX_W + 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sec_tick,
  input  logic [6:0]           now_sec,
  input  logic [6:0]           now_min,
  input  logic [6:0]           now_hour,
  input  logic [2:0]           now_wday,
  input  logic [5:0]           now_date,
  input  logic [4:0]           now_month,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_DW-1:0]    reg_wdata,
  input  logic [NUM_ALARM-1:0] flag_clr,
  output logic [NUM_ALARM-1:0] alarm_flag,
  output logic                 mfp_out
);
  cal_t now_cal;
  assign now_cal = {now_sec, now_min, now_hour, now_wday, now_date, now_month};

  logic eval_q;
  always_ff @(posedge clk) begin
    if (rst) eval_q <= 1'b0;
    else     eval_q <= sec_tick;
  end

  logic                 ctl_gp, ctl_pol;
  logic [NUM_ALARM-1:0] ctl_en;
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_gp  <= 1'b0;
      ctl_pol <= 1'b0;
      ctl_en  <= '0;
    end else if (reg_we && reg_addr[ADDR_W-1]) begin
      ctl_gp  <= reg_wdata[0];
      ctl_en  <= reg_wdata[NUM_ALARM:1];
      ctl_pol <= reg_wdata[NUM_ALARM+1];
    end
  end

  logic [NUM_ALARM-1:0] flags;

  for (genvar g = 0; g < NUM_ALARM; g++) begin : g_slot
    logic slot_we;
    assign slot_we = reg_we && !reg_addr[ADDR_W-1] && (reg_addr[3 +: IDX_W] == IDX_W'(g));
    alm_slot u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (slot_we),
      .wr_fld  (reg_addr[2:0]),
      .wr_data (reg_wdata),
      .now     (now_cal),
      .eval_i  (eval_q),
      .en_i    (ctl_en[g]),
      .clr_i   (flag_clr[g]),
      .flag_o  (flags[g])
    );
  end

  alm_pin #(.NUM_ALARM(NUM_ALARM)) u_pin (
    .clk   (clk),
    .rst   (rst),
    .en    (ctl_en),
    .flags (flags),
    .pol   (ctl_pol),
    .gp    (ctl_gp),
    .pin   (mfp_out)
  );

  assign alarm_flag = flags;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (alarm_flag == '0 && mfp_out == 1'b0)); // R1
endmodule

// File: tb/tb_dual_alarm_unit.sv
module tb_dual_alarm_unit;
  logic clk = 0;
  logic rst = 1;
  logic sec_tick = 0;
  logic [6:0] now_sec = 0, now_min = 0, now_hour = 0;
  logic [2:0] now_wday = 1;
  logic [5:0] now_date = 1;
  logic [4:0] now_month = 1;
  logic reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [6:0] reg_wdata = 0;
  logic [1:0] flag_clr = 0;
  logic [1:0] alarm_flag;
  logic mfp_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_alarm_unit dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_wday(now_wday), .now_date(now_date), .now_month(now_month),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .flag_clr(flag_clr), .alarm_flag(alarm_flag), .mfp_out(mfp_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [6:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk) reg_we = 0;
    @(negedge clk);
  endtask

  task automatic clr(input logic [1:0] m);
    flag_clr = m;
    @(negedge clk) flag_clr = 0;
    @(negedge clk);
  endtask

  task automatic tick();
    sec_tick = 1;
    @(negedge clk) sec_tick = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_now(input logic [6:0] s, m, h, input logic [2:0] w,
                         input logic [5:0] d, input logic [4:0] mo);
    now_sec = s; now_min = m; now_hour = h; now_wday = w; now_date = d; now_month = mo;
  endtask

  task automatic t_reset();
    chk("R1 flags", {6'd0, alarm_flag}, 8'h00);
    chk("R1 pin", {7'd0, mfp_out}, 8'h00);
  endtask

  task automatic t_gp();
    wr(5'h10, 7'h01);
    chk("R13 gp high", {7'd0, mfp_out}, 8'h01);
    wr(5'h10, 7'h00);
    chk("R13 gp low", {7'd0, mfp_out}, 8'h00);
  endtask

  task automatic t_sec_min();
    wr(5'h00, 7'h25);
    wr(5'h03, 7'h00);
    wr(5'h10, 7'h0B);
    chk("R12 idle pin inverse, gp ignored", {7'd0, mfp_out}, 8'h00);
    set_now(7'h24, 7'h00, 7'h00, 1, 1, 1);
    tick();
    chk("R3 sec miss", {6'd0, alarm_flag}, 8'h00);
    now_sec = 7'h25;
    tick();
    chk("R3 sec hit", {6'd0, alarm_flag}, 8'h01);
    chk("R12 pin active", {7'd0, mfp_out}, 8'h01);
    now_sec = 7'h26;
    tick();
    chk("R10 sticky", {6'd0, alarm_flag}, 8'h01);
    clr(2'b01);
    chk("R10 cleared", {6'd0, alarm_flag}, 8'h00);
    chk("R12 pin after clear", {7'd0, mfp_out}, 8'h00);
    now_sec = 7'h25;
    repeat (6) @(negedge clk);
    chk("R2 no tick no set", {6'd0, alarm_flag}, 8'h00);
    wr(5'h01, 7'h30);
    wr(5'h03, 7'h10);
    set_now(7'h00, 7'h30, 7'h00, 1, 1, 1);
    tick();
    chk("R3 min hit", {6'd0, alarm_flag}, 8'h01);
    clr(2'b01);
  endtask

  task automatic t_hour();
    wr(5'h0A, 7'h57);
    wr(5'h0B, 7'h20);
    wr(5'h10, 7'h0C);
    set_now(7'h11, 7'h30, 7'h17, 1, 1, 1);
    tick();
    chk("R5 R11 hour24 hit, a0 disabled", {6'd0, alarm_flag}, 8'h02);
    chk("R12 pin alarm1", {7'd0, mfp_out}, 8'h01);
    clr(2'b10);
    wr(5'h0A, 7'h27);
    now_hour = 7'h47;
    tick();
    chk("R4 AM vs PM miss", {6'd0, alarm_flag}, 8'h00);
    now_hour = 7'h67;
    tick();
    chk("R4 PM hit", {6'd0, alarm_flag}, 8'h02);
    clr(2'b10);
  endtask

  task automatic t_wday();
    wr(5'h03, 7'h33);
    wr(5'h10, 7'h0A);
    set_now(7'h00, 7'h00, 7'h00, 3, 1, 1);
    tick();
    chk("R6 midnight 24h", {6'd0, alarm_flag}, 8'h01);
    clr(2'b01);
    now_hour = 7'h01;
    tick();
    chk("R6 1am miss", {6'd0, alarm_flag}, 8'h00);
    now_hour = 7'h52;
    tick();
    chk("R6 midnight 12h", {6'd0, alarm_flag}, 8'h01);
    clr(2'b01);
    now_hour = 7'h72;
    tick();
    chk("R6 noon miss", {6'd0, alarm_flag}, 8'h00);
    now_hour = 7'h00; now_wday = 4;
    tick();
    chk("R6 other day miss", {6'd0, alarm_flag}, 8'h00);
  endtask

  task automatic t_date();
    wr(5'h04, 7'h15);
    wr(5'h03, 7'h40);
    set_now(7'h07, 7'h08, 7'h09, 2, 6'h15, 5'h03);
    tick();
    chk("R7 date hit", {6'd0, alarm_flag}, 8'h01);
    clr(2'b01);
    now_date = 6'h16;
    tick();
    chk("R7 date miss", {6'd0, alarm_flag}, 8'h00);
  endtask

  task automatic t_full();
    wr(5'h08, 7'h10); wr(5'h09, 7'h20); wr(5'h0A, 7'h08);
    wr(5'h0C, 7'h09); wr(5'h0D, 7'h11); wr(5'h0B, 7'h72);
    wr(5'h10, 7'h0C);
    set_now(7'h10, 7'h20, 7'h08, 2, 6'h09, 5'h11);
    tick();
    chk("R8 full hit", {6'd0, alarm_flag}, 8'h02);
    clr(2'b10);
    now_month = 5'h12;
    tick();
    chk("R8 month differs", {6'd0, alarm_flag}, 8'h00);
    now_month = 5'h11;
    wr(5'h0B, 7'h52);
    tick();
    chk("R9 code 101", {6'd0, alarm_flag}, 8'h00);
    wr(5'h0B, 7'h62);
    tick();
    chk("R9 code 110", {6'd0, alarm_flag}, 8'h00);
  endtask

  task automatic t_both_pol0();
    wr(5'h0B, 7'h72);
    wr(5'h10, 7'h07);
    chk("R12 pol0 idle", {7'd0, mfp_out}, 8'h01);
    tick();
    chk("R12 both flags", {6'd0, alarm_flag}, 8'h02);
    chk("R12 pol0 active", {7'd0, mfp_out}, 8'h00);
    clr(2'b10);
    chk("R12 pol0 back idle", {7'd0, mfp_out}, 8'h01);
  endtask

  task automatic t_set_wins();
    wr(5'h10, 7'h0C);
    sec_tick = 1;
    @(negedge clk) begin sec_tick = 0; flag_clr = 2'b10; end
    @(negedge clk) flag_clr = 0;
    chk("R10 set beats clear", {6'd0, alarm_flag}, 8'h02);
    clr(2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_gp();
    t_sec_min();
    t_hour();
    t_wday();
    t_date();
    t_full();
    t_both_pol0();
    t_set_wins();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule